// File: doc/BRIEF.md
# Cascaded watchdog reset timer

This block supervises software progress. A narrow low counter and a wider high counter are chained, and both count down. The low counter steps on a count enable taken from a free-running prescaler on the oscillator clock. Software picks a divide-by-8 or divide-by-16 rate for that enable with one select bit. Each time the low counter wraps from zero back to its full value, the high counter steps down by one. When the top bit of the high counter reaches zero, the block raises an internal reset request. That request stays high until the system reset returns the block to its idle state.

The watchdog is idle after reset. Both counters hold at all-ones and do not move. The first write to the high counter address arms the watchdog and starts the count. Every later write to that address reloads both counters to all-ones, whatever data is written. While the chip is in stop mode, the prescaler and both counters freeze, and they continue from the same point when stop mode ends. With the default widths and an 8 MHz oscillator, the time from a refresh to a trip is 16.384 ms at divide-by-8 and 32.768 ms at divide-by-16.

Top module: `cascade_watchdog`

## Requirements
- R1: After the synchronous reset, the low counter reads all-ones (0x7F by default), the high counter reads all-ones (0xFF by default) and the reset request is 0.
- R2: Until the first write to the high counter address after reset, both counter values hold still and the reset request stays 0, however many prescaler enables occur.
- R3: A cycle with `wr_hi` high sets both counters to all-ones on the next clock edge, whatever the value on `wr_data`. It also arms the watchdog.
- R4: Once armed, the low counter decreases by one on each prescaler enable. The enable comes every 2^FINE_LOG2 clocks (8 by default) when `src_sel` is 0, and every 2^COARSE_LOG2 clocks (16 by default) when `src_sel` is 1.
- R5: The high counter decreases by one exactly when the low counter wraps from 0 to all-ones, and it changes at no other time except on a reload.
- R6: The reset request rises on the clock edge after the high counter's top bit is first seen at 0.
- R7: Once the reset request is high, it stays high through later writes and stop mode, until the synchronous reset clears it.
- R8: While `stop_mode` is 1, the prescaler and both counters hold their values. When `stop_mode` returns to 0, the prescaler resumes from the phase it held.
- R9: If a write and a prescaler enable fall on the same cycle, the write wins: both counters read all-ones afterwards. The prescaler phase is not disturbed by the write.
- R10: After a write, the reset request rises one clock after the 2^LO_W × 2^(HI_W−1)-th prescaler enable that follows the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_hi | input | 1 | Write strobe for the high counter address (refresh) |
| wr_data | input | HI_W | Write data; has no effect |
| src_sel | input | 1 | Prescaler rate: 0 = divide by 2^FINE_LOG2, 1 = divide by 2^COARSE_LOG2 |
| stop_mode | input | 1 | Stop mode active; freezes all counting |
| rst_req | output | 1 | Internal reset request, held until `rst` |
| lo_val | output | LO_W | Current low counter value |
| hi_val | output | HI_W | Current high counter value |

## Verification
The bench builds the block with a 3-bit low counter and a 4-bit high counter, and keeps the default divide-by-8 and divide-by-16 rates. With these sizes a full expiry takes 512 or 1024 clocks. That makes the exact trip cycle, the behaviour after a trip and the release by reset all reachable many times within one run. The reload values become 7 and 15. Because the prescaler rates stay at their real values, the bench can measure the enable spacing, the phase held across stop mode, and a write placed on the same cycle as an enable.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Prescaler rate choice carried on the source-select input
    typedef enum logic {
        SRC_DIV_FINE   = 1'b0,
        SRC_DIV_COARSE = 1'b1
    } src_sel_e;

    // Control word that drives one down-counting stage
    typedef struct packed {
        logic load;   // reload to all-ones (highest priority)
        logic step;   // decrement by one
    } stage_ctl_t;

    // Number of prescaler enables from a reload until the high stage's
    // top bit first reads zero
    function automatic int unsigned trip_ticks(input int lo_w, input int hi_w);
        int unsigned lo_span;
        int unsigned hi_span;
        lo_span = 32'd1 << lo_w;
        hi_span = 32'd1 << (hi_w - 1);
        return lo_span * hi_span;
    endfunction

    // Mask whose low 'bits' positions are set
    function automatic int unsigned low_mask(input int bits);
        return (32'd1 << bits) - 32'd1;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int FINE_LOG2   = 3,
    parameter int COARSE_LOG2 = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  src_sel_e sel,
    output logic     tick
);
    localparam int PS_W = (COARSE_LOG2 > FINE_LOG2) ? COARSE_LOG2 : FINE_LOG2;
    localparam logic [PS_W-1:0] FINE_MASK   = PS_W'(low_mask(FINE_LOG2));
    localparam logic [PS_W-1:0] COARSE_MASK = PS_W'(low_mask(COARSE_LOG2));

    logic [PS_W-1:0] phase;
    logic [PS_W-1:0] sel_mask;

    // Free-running phase counter: held only while the oscillator is stopped
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (run) begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            SRC_DIV_COARSE: sel_mask = COARSE_MASK;
            default:        sel_mask = FINE_MASK;
        endcase
    end

    // Single-cycle enable when the selected low bits of the phase are all ones
    assign tick = run && ((phase & sel_mask) == sel_mask);

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(phase)); // R8

endmodule

// File: rtl/wdt_down_stage.sv
module wdt_down_stage
    import wdt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  stage_ctl_t   ctl,
    output logic [W-1:0] val,
    output logic         wrap
);
    localparam logic [W-1:0] FULL = '1;

    always_ff @(posedge clk) begin
        if (rst || ctl.load) begin
            val <= FULL;
        end else if (ctl.step) begin
            val <= val - 1'b1;
        end
    end

    // Underflow from zero back to all-ones on this cycle's step
    assign wrap = ctl.step && !ctl.load && (val == '0);

    AST_STAGE_LOAD_FULL: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (val == FULL)); // R3
    AST_STAGE_STEP_DEC: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ctl.load) |=> (val == W'($past(val) - 1'b1))); // R4
    AST_STAGE_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.step && !ctl.load) |=> $stable(val)); // R5

endmodule

// File: rtl/wdt_trip_latch.sv
module wdt_trip_latch (
    input  logic clk,
    input  logic rst,
    input  logic msb,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else if (!msb) begin
            req <= 1'b1;
        end
    end

    AST_REQ_ON_MSB_LOW: assert property (@(posedge clk) disable iff (rst)
        !msb |=> req); // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        req |=> req); // R7

endmodule

// File: rtl/cascade_watchdog.sv
module cascade_watchdog
    import wdt_pkg::*;
#(
    parameter int LO_W        = 7,
    parameter int HI_W        = 8,
    parameter int FINE_LOG2   = 3,
    parameter int COARSE_LOG2 = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_hi,
    input  logic [HI_W-1:0] wr_data,
    input  logic            src_sel,
    input  logic            stop_mode,
    output logic            rst_req,
    output logic [LO_W-1:0] lo_val,
    output logic [HI_W-1:0] hi_val
);
    localparam int unsigned TRIP_TICKS = trip_ticks(LO_W, HI_W);
    localparam logic [LO_W-1:0] LO_FULL = '1;
    localparam logic [HI_W-1:0] HI_FULL = '1;

    logic       armed;
    logic       osc_run;
    logic       div_tick;
    logic       lo_wrap;
    logic       hi_wrap_unused;
    logic       unused_wr_data;
    stage_ctl_t lo_ctl;
    stage_ctl_t hi_ctl;

    // The data written has no meaning; only the strobe matters
    assign unused_wr_data = ^wr_data;

    // Idle after reset; the first refresh arms the counter chain
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (wr_hi) begin
            armed <= 1'b1;
        end
    end

    assign osc_run = !stop_mode;

    wdt_prescaler #(
        .FINE_LOG2  (FINE_LOG2),
        .COARSE_LOG2(COARSE_LOG2)
    ) i_prescaler (
        .clk (clk),
        .rst (rst),
        .run (osc_run),
        .sel (src_sel_e'(src_sel)),
        .tick(div_tick)
    );

    // Refresh outranks a count step in both stages
    always_comb begin
        lo_ctl.load = wr_hi;
        lo_ctl.step = armed && div_tick && !wr_hi;
        hi_ctl.load = wr_hi;
        hi_ctl.step = lo_wrap;
    end

    wdt_down_stage #(.W(LO_W)) i_lo_stage (
        .clk (clk),
        .rst (rst),
        .ctl (lo_ctl),
        .val (lo_val),
        .wrap(lo_wrap)
    );

    wdt_down_stage #(.W(HI_W)) i_hi_stage (
        .clk (clk),
        .rst (rst),
        .ctl (hi_ctl),
        .val (hi_val),
        .wrap(hi_wrap_unused)
    );

    wdt_trip_latch i_trip (
        .clk(clk),
        .rst(rst),
        .msb(hi_val[HI_W-1]),
        .req(rst_req)
    );

    // Count of low-stage steps since the last refresh, kept for the trip check
    logic [31:0] steps_since_load;
    always_ff @(posedge clk) begin
        if (rst || wr_hi) begin
            steps_since_load <= '0;
        end else if (lo_ctl.step && (steps_since_load != '1)) begin
            steps_since_load <= steps_since_load + 1'b1;
        end
    end

    AST_DORMANT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!armed && !wr_hi) |=> ($stable(lo_val) && $stable(hi_val))); // R2
    AST_REFRESH_FULL: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> ((lo_val == LO_FULL) && (hi_val == HI_FULL))); // R3
    AST_HI_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!wr_hi && !lo_wrap) |=> $stable(hi_val)); // R5
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && !wr_hi) |=> ($stable(lo_val) && $stable(hi_val))); // R8
    AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && div_tick && armed) |=> (lo_val == LO_FULL)); // R9
    AST_TRIP_TICKS: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> (steps_since_load == TRIP_TICKS)); // R10

endmodule

// File: tb/test_cascade_watchdog.sv
module test_cascade_watchdog;
    localparam int LO_W        = 3;
    localparam int HI_W        = 4;
    localparam int FINE_LOG2   = 3;
    localparam int COARSE_LOG2 = 4;
    localparam int LO_MAX      = (1 << LO_W) - 1;
    localparam int HI_MAX      = (1 << HI_W) - 1;
    localparam int TICKS       = (1 << LO_W) * (1 << (HI_W - 1));
    localparam int LIMIT       = 150000;

    typedef struct packed {
        logic            sel;
        logic [HI_W-1:0] data;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 4'h0},
        '{1'b1, 4'hA},
        '{1'b0, 4'h5},
        '{1'b1, 4'hF}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_hi = 1'b0;
    logic [HI_W-1:0] wr_data = '0;
    logic            src_sel = 1'b0;
    logic            stop_mode = 1'b0;
    logic            rst_req;
    logic [LO_W-1:0] lo_val;
    logic [HI_W-1:0] hi_val;

    cascade_watchdog #(
        .LO_W(LO_W), .HI_W(HI_W), .FINE_LOG2(FINE_LOG2), .COARSE_LOG2(COARSE_LOG2)
    ) i_cascade_watchdog (
        .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_data(wr_data),
        .src_sel(src_sel), .stop_mode(stop_mode),
        .rst_req(rst_req), .lo_val(lo_val), .hi_val(hi_val)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always @(posedge clk) begin
        if (!done && cyc >= LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung actual=%0d expected<%0d", cyc, LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_hi = 1'b0; stop_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic do_write(input logic [HI_W-1:0] d, output int wt);
        wr_hi = 1'b1; wr_data = d;
        @(negedge clk);
        wr_hi = 1'b0; wr_data = ~d;
        wt = cyc;
    endtask

    task automatic wait_lo_change(output int at);
        logic [LO_W-1:0] prev;
        prev = lo_val;
        at = -1;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (lo_val != prev) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic wait_hi_change(output int at);
        logic [HI_W-1:0] prev;
        prev = hi_val;
        at = -1;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (hi_val != prev) begin
                at = cyc;
                break;
            end
        end
    endtask

    initial begin
        int wt, e1, e2, e3, ter, tn, d;
        logic [LO_W-1:0] lo_s;
        logic [HI_W-1:0] hi_s;

        do_reset();
        // R1: reset state
        check("R1 lo after reset", int'(lo_val), LO_MAX);
        check("R1 hi after reset", int'(hi_val), HI_MAX);
        check("R1 req after reset", int'(rst_req), 0);

        // R2: idle until first write, through many prescaler enables
        repeat (150) @(negedge clk);
        check("R2 lo idle", int'(lo_val), LO_MAX);
        check("R2 hi idle", int'(hi_val), HI_MAX);
        check("R2 req idle", int'(rst_req), 0);

        // Table walk: rate select and write data
        for (int v = 0; v < 4; v++) begin
            do_reset();
            src_sel = VECS[v].sel;
            d = VECS[v].sel ? (1 << COARSE_LOG2) : (1 << FINE_LOG2);
            do_write(VECS[v].data, wt);
            check("R3 lo reload", int'(lo_val), LO_MAX);
            check("R3 hi reload", int'(hi_val), HI_MAX);
            wait_lo_change(e1);
            check("R4 first step value", int'(lo_val), LO_MAX - 1);
            wait_lo_change(e2);
            check("R4 step spacing", e2 - e1, d);
            wait_hi_change(e3);
            check("R5 hi after wrap", int'(hi_val), HI_MAX - 1);
            check("R5 lo at wrap", int'(lo_val), LO_MAX);
            check("R5 wrap timing", e3 - e1, LO_MAX * d);
            for (int n = 0; n < 3000 && !rst_req; n++) @(negedge clk);
            ter = cyc;
            check("R10 trip cycle", ter, e1 + (TICKS - 1) * d + 1);
            check("R6 hi msb low at trip", int'(hi_val[HI_W-1]), 0);
            do_write(VECS[v].data, wt);
            check("R7 req held after write", int'(rst_req), 1);
            check("R3 lo reload after trip", int'(lo_val), LO_MAX);
            stop_mode = 1'b1;
            repeat (20) @(negedge clk);
            stop_mode = 1'b0;
            check("R7 req held later", int'(rst_req), 1);
        end

        // R7: only reset clears the request; block returns to idle
        do_reset();
        check("R7 req cleared by reset", int'(rst_req), 0);
        repeat (60) @(negedge clk);
        check("R2 idle after release lo", int'(lo_val), LO_MAX);
        check("R2 idle after release req", int'(rst_req), 0);

        // R8: stop freezes counters and prescaler phase
        do_reset();
        src_sel = 1'b0;
        do_write(4'h3, wt);
        wait_lo_change(e1);
        repeat (3) @(negedge clk);
        stop_mode = 1'b1;
        lo_s = lo_val; hi_s = hi_val;
        repeat (40) @(negedge clk);
        check("R8 lo frozen", int'(lo_val), int'(lo_s));
        check("R8 hi frozen", int'(hi_val), int'(hi_s));
        stop_mode = 1'b0;
        wait_lo_change(tn);
        check("R8 phase kept across stop", tn, e1 + 48);

        // R9: write on the same cycle as an enable
        do_reset();
        src_sel = 1'b0;
        do_write(4'h9, wt);
        wait_hi_change(e3);
        check("R9 hi moved before test", int'(hi_val), HI_MAX - 1);
        repeat (7) @(negedge clk);
        do_write(4'h6, wt);
        check("R9 write edge on enable", wt, e3 + 8);
        check("R9 lo after coincident write", int'(lo_val), LO_MAX);
        check("R9 hi after coincident write", int'(hi_val), HI_MAX);
        wait_lo_change(tn);
        check("R9 prescaler phase kept", tn, e3 + 16);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule